// File: doc/BRIEF.md
# Serial Quadtree Partition Mode Decision

This block chooses the partitioning of a 32x32 coding tree block for inter prediction, working from matching costs that an upstream comparator stage has already reduced to one best cost per prediction-block shape. Costs arrive as a stream, one per cycle at most. Each beat carries a level code, a mode code and a cost. The block adds a fixed per-mode rate penalty to each cost. It keeps a running minimum over the modes of the coding block in flight. When a block's last mode arrives, it records the winning mode and cost. For each 16x16 and 32x32 block it then decides whether the four children together are cheaper than the block left whole.

The stream runs in quadtree order. For each quadrant 0..3, the four 8x8 blocks come in z-order, each sending modes 0..2. The quadrant's own 16x16 modes 0..7 follow. After all four quadrants, the 32x32 modes 0..7 close the run. A start pulse opens a run. A done pulse marks the end of the run, and the result stays on the outputs until the next start.

The four child costs are reduced with three adders as soon as they are known. The split decision therefore costs no extra cycle, and beats may arrive back to back for the whole run.

Top module: `md_quadtree_decide`

## Requirements
- R1: After reset, done_o, split16_o, split32_o, all mode outputs and total_o are zero.
- R2: The candidate cost of a beat is cost_i plus the penalty field pen_i[PW*m +: PW], where m is mode_i. The best cost of a block is the smallest candidate among its modes.
- R3: Mode codes are 0 = 2Nx2N, 1 = 2NxN, 2 = Nx2N, 3 = NxN, 4 = asymmetric up, 5 = asymmetric down, 6 = asymmetric left, 7 = asymmetric right. For 16x16 and 32x32 blocks all eight modes compete. When two candidates are equal, the lower mode code wins.
- R4: Level codes are 0 = 8x8, 1 = 16x16, 2 = 32x32. A level-0 beat with mode code 3 or above (4x4 or asymmetric shapes) is ignored, and so is any beat with level code 3. An ignored beat changes no result.
- R5: A 16x16 block is split (split16_o bit q, quadrant q) only when the sum of its four 8x8 best costs is strictly less than its own best cost. On a tie the block stays whole. Its chosen cost is the smaller of the two.
- R6: The 32x32 block is split (split32_o) only when the sum of the four chosen 16x16 costs is strictly less than its own best cost. total_o is the smaller of the two values, and a tie keeps the block whole.
- R7: done_o is high for exactly one cycle, the cycle right after the level-2 mode-7 beat is accepted.
- R8: After done, every output holds its value until the next start_i. Beats presented while no run is open are ignored.
- R9: Beats may arrive on consecutive cycles or with idle gaps between them, with no stall. mode8_o[3i +: 3] holds the best mode of 8x8 block i, where i = 4*quadrant + z-order position, and mode16_o[3q +: 3] holds the best mode of quadrant q.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Opens a run and clears the stream position |
| valid_i | input | 1 | Beat strobe |
| lvl_i | input | 2 | Level code of the beat |
| mode_i | input | 3 | Mode code of the beat |
| cost_i | input | CW | Matching cost of the beat |
| pen_i | input | 8*PW | Rate penalty per mode code |
| done_o | output | 1 | Run-complete pulse |
| split32_o | output | 1 | 32x32 block split into quadrants |
| split16_o | output | 4 | Per-quadrant split flags |
| mode32_o | output | 3 | Best 32x32 mode |
| mode16_o | output | 12 | Best 16x16 mode per quadrant |
| mode8_o | output | 48 | Best 8x8 mode per block |
| total_o | output | CW+6 | Cost of the chosen tree |

## Verification
Two things fall in the same cycle. The beat that carries a block's last mode closes the running minimum, and the split comparison uses that fresh minimum against the summed child costs in the same cycle. The bench provokes this with cases where the final mode (code 7) is the cheapest, and where that cost exactly equals the children's sum, so a one-cycle lag or a wrong tie rule gives a different mode code or split flag. Back-to-back streaming also puts a quadrant's last 16x16 beat directly before the first 32x32 beat, and every result is judged against an independent model of R2 to R6.

// File: rtl/md_pkg.sv
package md_pkg;
  localparam int MW = 3;
  localparam int NMODE = 8;

  typedef enum logic [MW-1:0] {
    MD_2NX2N = 3'd0,
    MD_2NXN  = 3'd1,
    MD_NX2N  = 3'd2,
    MD_NXN   = 3'd3,
    MD_AMP_U = 3'd4,
    MD_AMP_D = 3'd5,
    MD_AMP_L = 3'd6,
    MD_AMP_R = 3'd7
  } pu_mode_e;

  localparam logic [1:0] LVL_8  = 2'd0;
  localparam logic [1:0] LVL_16 = 2'd1;
  localparam logic [1:0] LVL_32 = 2'd2;
endpackage

// File: rtl/md_run_min.sv
module md_run_min #(
  parameter int SW = 22,
  parameter int MW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          first_i,
  input  logic [SW-1:0] cand_i,
  input  logic [MW-1:0] mode_i,
  output logic [SW-1:0] best_o,
  output logic [MW-1:0] mode_o
);
  logic [SW-1:0] best_q;
  logic [MW-1:0] mode_q;
  logic          take;

  // strict less: lower mode code keeps a tie
  assign take   = first_i || (cand_i < best_q);
  assign best_o = take ? cand_i : best_q;
  assign mode_o = take ? mode_i : mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      best_q <= '0;
      mode_q <= '0;
    end else if (en_i) begin
      best_q <= best_o;
      mode_q <= mode_o;
    end
  end

  // R2
  min_monotonic_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !first_i) |=> (best_q <= $past(best_q)));
endmodule

// File: rtl/md_sum4.sv
module md_sum4 #(
  parameter int SW = 22
) (
  input  logic [3:0][SW-1:0] v_i,
  output logic [SW-1:0]      sum_o
);
  logic [1:0][SW-1:0] pair;

  for (genvar g = 0; g < 2; g++) begin : g_pair
    assign pair[g] = v_i[2*g] + v_i[2*g+1];
  end
  assign sum_o = pair[0] + pair[1];
endmodule

// File: rtl/md_quadtree_decide.sv
module md_quadtree_decide
  import md_pkg::*;
#(
  parameter int CW = 16,
  parameter int PW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              valid_i,
  input  logic [1:0]        lvl_i,
  input  logic [2:0]        mode_i,
  input  logic [CW-1:0]     cost_i,
  input  logic [8*PW-1:0]   pen_i,
  output logic              done_o,
  output logic              split32_o,
  output logic [3:0]        split16_o,
  output logic [2:0]        mode32_o,
  output logic [11:0]       mode16_o,
  output logic [47:0]       mode8_o,
  output logic [CW+5:0]     total_o
);
  localparam int SW   = CW + 6;
  localparam int NB8  = 16;
  localparam int NB16 = 4;
  localparam int B8W  = $clog2(NB8);
  localparam int B16W = $clog2(NB16);

  logic            busy_q, first_q, done_q;
  logic [B8W-1:0]  cnt8_q;
  logic [B16W-1:0] cnt16_q;
  logic [SW-1:0]   cost8_q [NB8];
  logic [SW-1:0]   c16_q   [NB16];
  logic [MW-1:0]   mode8_q [NB8];
  logic [MW-1:0]   mode16_q[NB16];
  logic [MW-1:0]   mode32_q;
  logic [NB16-1:0] split16_q;
  logic            split32_q;
  logic [SW-1:0]   total_q;

  logic            legal, acc, last;
  logic [PW-1:0]   pen_sel;
  logic [SW-1:0]   cand, nbest, sum8, sum16;
  logic [MW-1:0]   nmode;
  logic [3:0][SW-1:0] kids8, kids16;

  assign legal   = (lvl_i == LVL_8) ? (mode_i <= MD_NX2N) : (lvl_i != 2'd3);
  assign acc     = valid_i && busy_q && !start_i && legal;
  assign last    = (lvl_i == LVL_8) ? (mode_i == MD_NX2N) : (mode_i == MD_AMP_R);
  assign pen_sel = pen_i[mode_i*PW +: PW];
  assign cand    = SW'(cost_i) + SW'(pen_sel);

  md_run_min #(.SW(SW), .MW(MW)) u_min (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (acc),
    .first_i (first_q),
    .cand_i  (cand),
    .mode_i  (mode_i),
    .best_o  (nbest),
    .mode_o  (nmode)
  );

  for (genvar g = 0; g < 4; g++) begin : g_kids
    assign kids8[g]  = cost8_q[{cnt16_q, 2'(g)}];
    assign kids16[g] = c16_q[g];
  end

  md_sum4 #(.SW(SW)) u_sum8  (.v_i(kids8),  .sum_o(sum8));
  md_sum4 #(.SW(SW)) u_sum16 (.v_i(kids16), .sum_o(sum16));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      first_q   <= 1'b1;
      done_q    <= 1'b0;
      cnt8_q    <= '0;
      cnt16_q   <= '0;
      split16_q <= '0;
      split32_q <= 1'b0;
      mode32_q  <= '0;
      total_q   <= '0;
      for (int i = 0; i < NB8; i++) begin
        cost8_q[i] <= '0;
        mode8_q[i] <= '0;
      end
      for (int i = 0; i < NB16; i++) begin
        c16_q[i]    <= '0;
        mode16_q[i] <= '0;
      end
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        busy_q  <= 1'b1;
        first_q <= 1'b1;
        cnt8_q  <= '0;
        cnt16_q <= '0;
      end else if (acc) begin
        first_q <= last;
        if (last) begin
          unique case (lvl_i)
            LVL_8: begin
              cost8_q[cnt8_q] <= nbest;
              mode8_q[cnt8_q] <= nmode;
              cnt8_q          <= cnt8_q + 1'b1;
            end
            LVL_16: begin
              split16_q[cnt16_q] <= (sum8 < nbest);
              c16_q[cnt16_q]     <= (sum8 < nbest) ? sum8 : nbest;
              mode16_q[cnt16_q]  <= nmode;
              cnt16_q            <= cnt16_q + 1'b1;
            end
            default: begin
              split32_q <= (sum16 < nbest);
              total_q   <= (sum16 < nbest) ? sum16 : nbest;
              mode32_q  <= nmode;
              busy_q    <= 1'b0;
              done_q    <= 1'b1;
            end
          endcase
        end
      end
    end
  end

  for (genvar g = 0; g < NB8; g++) begin : g_m8
    assign mode8_o[MW*g +: MW] = mode8_q[g];
  end
  for (genvar g = 0; g < NB16; g++) begin : g_m16
    assign mode16_o[MW*g +: MW] = mode16_q[g];
  end

  assign done_o    = done_q;
  assign split32_o = split32_q;
  assign split16_o = split16_q;
  assign mode32_o  = mode32_q;
  assign total_o   = total_q;

  // R7
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R7
  done_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(valid_i && busy_q && lvl_i == LVL_32 && mode_i == MD_AMP_R));

  // R8
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && !start_i) |=> ($stable(total_o) && $stable(split16_o) &&
      $stable(split32_o) && $stable(mode8_o) && $stable(mode16_o) && $stable(mode32_o)));
endmodule

// File: tb/md_quadtree_decide_bench.sv
module md_quadtree_decide_bench;
  localparam int CW = 16;
  localparam int PW = 8;
  localparam int SW = CW + 6;
  localparam int NV = 6;
  // stimulus vectors: seed and stream style (bit0 = junk beats, bit1 = idle gaps)
  localparam int VEC_SEED [NV] = '{7, 131, 977, 2203, 41, 613};
  localparam int VEC_MODE [NV] = '{0, 1, 2, 3, 0, 1};

  logic            clk = 1'b0;
  logic            rst_ni, start_i, valid_i;
  logic [1:0]      lvl_i;
  logic [2:0]      mode_i;
  logic [CW-1:0]   cost_i;
  logic [8*PW-1:0] pen_i;
  logic            done_o, split32_o;
  logic [3:0]      split16_o;
  logic [2:0]      mode32_o;
  logic [11:0]     mode16_o;
  logic [47:0]     mode8_o;
  logic [SW-1:0]   total_o;

  int c8 [16][3];
  int c16[4][8];
  int c32[8];
  int pen[8];
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  md_quadtree_decide #(.CW(CW), .PW(PW)) u_md_quadtree_decide (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .valid_i(valid_i),
    .lvl_i(lvl_i), .mode_i(mode_i), .cost_i(cost_i), .pen_i(pen_i),
    .done_o(done_o), .split32_o(split32_o), .split16_o(split16_o),
    .mode32_o(mode32_o), .mode16_o(mode16_o), .mode8_o(mode8_o), .total_o(total_o)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic beat(input int lvl, input int mode, input int cost);
    valid_i = 1'b1;
    lvl_i   = 2'(lvl);
    mode_i  = 3'(mode);
    cost_i  = CW'(cost);
    @(negedge clk);
    valid_i = 1'b0;
  endtask

  task automatic load_pen();
    for (int m = 0; m < 8; m++) pen_i[m*PW +: PW] = PW'(pen[m]);
  endtask

  function automatic int gen(input int seed, input int k, input int modv);
    return ((seed * (k * 37 + 11)) ^ (k * k * 53)) % modv;
  endfunction

  task automatic fill(input int seed);
    for (int i = 0; i < 16; i++)
      for (int m = 0; m < 3; m++) c8[i][m] = gen(seed, i*3 + m, 100 + seed % 400);
    for (int q = 0; q < 4; q++)
      for (int m = 0; m < 8; m++) c16[q][m] = gen(seed, 60 + q*8 + m, 2000);
    for (int m = 0; m < 8; m++) c32[m] = gen(seed, 100 + m, 6000);
    for (int m = 0; m < 8; m++) pen[m] = gen(seed, 200 + m, 30);
  endtask

  // R9: back-to-back or gapped stream; R4: optional junk beats
  task automatic run_stream(input bit junk, input bit gaps);
    load_pen();
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int q = 0; q < 4; q++) begin
      for (int s = 0; s < 4; s++) begin
        for (int m = 0; m < 3; m++) beat(0, m, c8[q*4+s][m]);
        if (gaps) @(negedge clk);
        if (junk && q == 1 && s == 0) begin
          beat(0, 3, 0);
          beat(0, 6, 0);
          beat(3, 0, 0);
        end
      end
      for (int m = 0; m < 8; m++) beat(1, m, c16[q][m]);
    end
    for (int m = 0; m < 7; m++) beat(2, m, c32[m]);
    beat(2, 7, c32[7]);
    chk(done_o === 1'b1, "R7 done after last beat", done_o, 1);
    @(negedge clk);
    chk(done_o === 1'b0, "R7 done single cycle", done_o, 0);
  endtask

  task automatic check_results(input string tag);
    int b8[16], m8[16], b16[4], m16[4], ch16[4], s, b32, m32, s32, tot;
    bit sp16[4], sp32;
    for (int i = 0; i < 16; i++) begin
      b8[i] = c8[i][0] + pen[0]; m8[i] = 0;
      for (int m = 1; m < 3; m++)
        if (c8[i][m] + pen[m] < b8[i]) begin b8[i] = c8[i][m] + pen[m]; m8[i] = m; end
    end
    for (int q = 0; q < 4; q++) begin
      b16[q] = c16[q][0] + pen[0]; m16[q] = 0;
      for (int m = 1; m < 8; m++)
        if (c16[q][m] + pen[m] < b16[q]) begin b16[q] = c16[q][m] + pen[m]; m16[q] = m; end
      s = b8[4*q] + b8[4*q+1] + b8[4*q+2] + b8[4*q+3];
      sp16[q] = s < b16[q];
      ch16[q] = sp16[q] ? s : b16[q];
    end
    b32 = c32[0] + pen[0]; m32 = 0;
    for (int m = 1; m < 8; m++)
      if (c32[m] + pen[m] < b32) begin b32 = c32[m] + pen[m]; m32 = m; end
    s32 = ch16[0] + ch16[1] + ch16[2] + ch16[3];
    sp32 = s32 < b32;
    tot = sp32 ? s32 : b32;
    for (int i = 0; i < 16; i++)
      chk(mode8_o[3*i +: 3] == 3'(m8[i]), {tag, " R2 R9 8x8 mode"}, mode8_o[3*i +: 3], m8[i]);
    for (int q = 0; q < 4; q++) begin
      chk(mode16_o[3*q +: 3] == 3'(m16[q]), {tag, " R3 16x16 mode"}, mode16_o[3*q +: 3], m16[q]);
      chk(split16_o[q] == sp16[q], {tag, " R5 16x16 split"}, split16_o[q], sp16[q]);
    end
    chk(mode32_o == 3'(m32), {tag, " R3 32x32 mode"}, mode32_o, m32);
    chk(split32_o == sp32, {tag, " R6 32x32 split"}, split32_o, sp32);
    chk(total_o == SW'(tot), {tag, " R6 total"}, total_o, tot);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [SW-1:0] t_hold;
    rst_ni = 1'b0; start_i = 1'b0; valid_i = 1'b0;
    lvl_i = '0; mode_i = '0; cost_i = '0; pen_i = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1
    chk(done_o === 1'b0 && split32_o === 1'b0 && split16_o === 4'd0, "R1 reset flags",
        {split32_o, split16_o, done_o}, 0);
    chk(mode8_o === '0 && mode16_o === '0 && mode32_o === '0 && total_o === '0,
        "R1 reset values", total_o, 0);

    // vector table
    for (int v = 0; v < NV; v++) begin
      fill(VEC_SEED[v]);
      run_stream(VEC_MODE[v][0], VEC_MODE[v][1]);
      check_results($sformatf("vec%0d", v));
    end

    // R5 R6 R3: all equal, lower code and whole block win
    for (int i = 0; i < 16; i++) for (int m = 0; m < 3; m++) c8[i][m] = 100;
    for (int q = 0; q < 4; q++) for (int m = 0; m < 8; m++) c16[q][m] = 100;
    for (int m = 0; m < 8; m++) begin c32[m] = 100; pen[m] = 0; end
    run_stream(1'b0, 1'b0);
    check_results("ties");

    // R5 R6: children strictly cheaper everywhere
    for (int i = 0; i < 16; i++) for (int m = 0; m < 3; m++) c8[i][m] = 1 + m;
    for (int q = 0; q < 4; q++) for (int m = 0; m < 8; m++) c16[q][m] = 1000;
    for (int m = 0; m < 8; m++) begin c32[m] = 1000; pen[m] = 2; end
    run_stream(1'b0, 1'b0);
    check_results("split_all");

    // R3 R5 R6: last mode cheapest and equal to children sum
    for (int i = 0; i < 16; i++) for (int m = 0; m < 3; m++) c8[i][m] = 25;
    for (int q = 0; q < 4; q++) begin
      for (int m = 0; m < 7; m++) c16[q][m] = 200;
      c16[q][7] = 100;
    end
    for (int m = 0; m < 7; m++) c32[m] = 500;
    c32[7] = 400;
    for (int m = 0; m < 8; m++) pen[m] = 0;
    run_stream(1'b1, 1'b0);
    check_results("last_tie");
    chk(mode32_o == 3'd7 && split32_o == 1'b0, "R6 tie keeps 32x32 whole", mode32_o, 7);

    // R8: beats while idle are ignored, outputs hold
    t_hold = total_o;
    beat(2, 0, 0);
    beat(2, 7, 0);
    chk(done_o === 1'b0, "R8 no done while idle", done_o, 0);
    repeat (3) @(negedge clk);
    chk(total_o == t_hold, "R8 total holds", total_o, t_hold);
    check_results("hold");

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule